// File: doc/BRIEF.md
# Split-Group Redundant Multiplier Voter

This block runs several identical copies of a small unsigned array multiplier on one shared pair of operands and merges their products into one result. Each output bit is merged on its own. Three copies form a voting trio whose two-of-three result is ANDed with the OR of every other copy, the spare pool. Adding one copy to the spare pool lets the block tolerate one more failed copy. A conventional majority voter would need two extra copies for the same gain.

Each copy has its own fault-injection fields, so a test can flip or pin any product bit of any copy. The trio result, the spare-pool result and a per-bit disagreement flag are brought out next to the voted product. The disagreement flag shows that a fault is present without changing the voted value. An optional output stage registers all four results.

Top module: `split_vote_mult`

## Requirements
- R1: With every fault field at zero, `vote_out`, `trio_out` and `pool_out` all equal the unsigned product `op_a * op_b`, which is 2*OPW bits wide.
- R2: Fault fields are packed per copy: bit b of copy k sits at index k*2*OPW+b. The faulted bit of a copy is `force_val` where `force_en` is 1. Otherwise it is the true product bit XOR `flip_mask`.
- R3: Each bit of `trio_out` is the two-of-three majority of copies 0, 1 and 2 after fault injection.
- R4: Each bit of `pool_out` is the OR of copies 3 to NUM_COPIES-1 after fault injection.
- R5: `vote_out` is the bitwise AND of the trio result and the pool result.
- R6: On a product bit that should be 1, `vote_out` stays correct when at most one trio copy is wrong and at least one pool copy is correct.
- R7: On a product bit that should be 0, `vote_out` stays correct when at most one trio copy is wrong, whatever the pool copies do.
- R8: When two trio copies are pinned to 0 on every bit, `vote_out` is 0.
- R9: Each bit of `mismatch` is 1 exactly when the trio and pool results differ on that bit.
- R10: With OUT_REG set, all four outputs change only one clock edge after the inputs. A synchronous active-high `rst` clears all four outputs to 0.
- R11: NUM_COPIES must be at least 4, which keeps at least one copy in the pool. Elaboration stops with an error otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | OPW | Multiplicand shared by all copies |
| op_b | input | OPW | Multiplier shared by all copies |
| flip_mask | input | NUM_COPIES*2*OPW | Per-copy, per-bit inversion of the product |
| force_en | input | NUM_COPIES*2*OPW | Per-copy, per-bit stuck-value enable |
| force_val | input | NUM_COPIES*2*OPW | Value used where `force_en` is set |
| vote_out | output | 2*OPW | Voted product |
| trio_out | output | 2*OPW | Two-of-three result of copies 0 to 2 |
| pool_out | output | 2*OPW | OR of copies 3 and above |
| mismatch | output | 2*OPW | Trio and pool disagree on this bit |

## Verification
The bench builds three instances with five, six and seven copies, which gives pools of two, three and four copies. All three use four-bit operands and the registered output. Each fault scenario is applied to all 256 operand pairs. The five-copy build shows that a tolerated scenario is cut back to fit a smaller pool, while the seven-copy build tolerates four copies failing at once. Directed cases cover the one-cycle latency, reset during live inputs, single-bit field placement, and a pool fault that is only flagged on `mismatch`.

// File: rtl/split_vote_mult.sv
module split_vote_mult #(
  parameter int NUM_COPIES = 5,
  parameter int OPW        = 4,
  parameter bit OUT_REG    = 1'b1,
  localparam int PW        = 2 * OPW,
  localparam int MW        = NUM_COPIES * PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic [MW-1:0]  flip_mask,
  input  logic [MW-1:0]  force_en,
  input  logic [MW-1:0]  force_val,
  output logic [PW-1:0]  vote_out,
  output logic [PW-1:0]  trio_out,
  output logic [PW-1:0]  pool_out,
  output logic [PW-1:0]  mismatch
);

  if (NUM_COPIES < 4) begin : g_bad_count
    $error("split_vote_mult: NUM_COPIES must be 4 or more (R11)");
  end

  wire [PW-1:0] mod_out [NUM_COPIES];

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
    wire [OPW-1:0] pp [OPW];
    wire [OPW-1:0] sr [OPW];
    wire [OPW-2:0] cr [OPW];
    wire [OPW-1:0] rc;
    wire [PW-1:0]  prod;

    for (genvar i = 0; i < OPW; i++) begin : g_pp_row
      for (genvar j = 0; j < OPW; j++) begin : g_pp_col
        assign pp[i][j] = op_a[j] & op_b[i];
      end
    end

    assign sr[0] = pp[0];
    assign cr[0] = '0;

    for (genvar i = 1; i < OPW; i++) begin : g_row
      for (genvar j = 0; j < OPW - 1; j++) begin : g_cell
        wire x = pp[i][j];
        wire y = sr[i-1][j+1];
        wire z = cr[i-1][j];
        assign sr[i][j] = x ^ y ^ z;
        assign cr[i][j] = (x & y) | (x & z) | (y & z);
      end
      assign sr[i][OPW-1] = pp[i][OPW-1];
    end

    for (genvar i = 0; i < OPW; i++) begin : g_low
      assign prod[i] = sr[i][0];
    end

    assign rc[0] = 1'b0;
    for (genvar j = 0; j < OPW - 1; j++) begin : g_ripple
      wire x = sr[OPW-1][j+1];
      wire y = cr[OPW-1][j];
      wire z = rc[j];
      assign prod[OPW+j] = x ^ y ^ z;
      assign rc[j+1]     = (x & y) | (x & z) | (y & z);
    end
    assign prod[PW-1] = rc[OPW-1];

    wire [PW-1:0] fe = force_en[k*PW +: PW];
    assign mod_out[k] = (fe & force_val[k*PW +: PW]) |
                        (~fe & (prod ^ flip_mask[k*PW +: PW]));
  end

  wire [PW-1:0] trio_c = (mod_out[0] & mod_out[1]) |
                         (mod_out[1] & mod_out[2]) |
                         (mod_out[0] & mod_out[2]);
  logic [PW-1:0] pool_c;

  always_comb begin
    pool_c = '0;
    for (int k = 3; k < NUM_COPIES; k++) pool_c = pool_c | mod_out[k];
  end

  wire [PW-1:0] vote_c = trio_c & pool_c;
  wire [PW-1:0] mism_c = trio_c ^ pool_c;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        vote_out <= '0;
        trio_out <= '0;
        pool_out <= '0;
        mismatch <= '0;
      end else begin
        vote_out <= vote_c;
        trio_out <= trio_c;
        pool_out <= pool_c;
        mismatch <= mism_c;
      end
    end
  end else begin : g_comb
    assign vote_out = vote_c;
    assign trio_out = trio_c;
    assign pool_out = pool_c;
    assign mismatch = mism_c;
  end

endmodule

// File: rtl/split_vote_mult_chk.sv
module split_vote_mult_chk #(
  parameter int NUM_COPIES = 5,
  parameter int OPW        = 4,
  parameter bit OUT_REG    = 1'b1,
  localparam int PW        = 2 * OPW,
  localparam int MW        = NUM_COPIES * PW
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] op_a,
  input logic [OPW-1:0] op_b,
  input logic [MW-1:0]  flip_mask,
  input logic [MW-1:0]  force_en,
  input logic [MW-1:0]  force_val,
  input logic [PW-1:0]  vote_out,
  input logic [PW-1:0]  trio_out,
  input logic [PW-1:0]  pool_out,
  input logic [PW-1:0]  mismatch
);

  logic [PW-1:0] prod_c;
  logic [PW-1:0] pool_clean_any;
  logic          trio_clean;
  logic          no_fault;
  logic          ones_covered;
  logic [PW-1:0] unused_val;

  always_comb begin
    prod_c     = PW'(op_a) * PW'(op_b);
    no_fault   = (flip_mask == '0) && (force_en == '0);
    trio_clean = ((flip_mask[3*PW-1:0] | force_en[3*PW-1:0]) == '0);
    pool_clean_any = '0;
    for (int k = 3; k < NUM_COPIES; k++)
      pool_clean_any = pool_clean_any | ~(flip_mask[k*PW +: PW] | force_en[k*PW +: PW]);
    ones_covered = &(pool_clean_any | ~prod_c);
    unused_val = force_val[PW-1:0];
  end

  if (OUT_REG) begin : g_props
    a_r1_clean_product: assert property (@(posedge clk) disable iff (rst)
      no_fault |=> (vote_out == $past(prod_c) && trio_out == $past(prod_c) &&
                    pool_out == $past(prod_c)));

    a_r9_quiet_when_clean: assert property (@(posedge clk) disable iff (rst)
      no_fault |=> (mismatch == '0));

    a_r7_zero_bits_hold: assert property (@(posedge clk) disable iff (rst)
      trio_clean |=> ((vote_out & ~$past(prod_c)) == '0));

    a_r6_ones_survive: assert property (@(posedge clk) disable iff (rst)
      (trio_clean && ones_covered) |=> (vote_out == $past(prod_c)));

    a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (vote_out == '0 && trio_out == '0 && pool_out == '0 && mismatch == '0));
  end

endmodule

bind split_vote_mult split_vote_mult_chk #(
  .NUM_COPIES(NUM_COPIES), .OPW(OPW), .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/split_vote_mult_tb.sv
module split_vote_mult_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  op_a = '0;
  logic [3:0]  op_b = '0;
  logic [55:0] fl = '0, fe = '0, fv = '0;
  logic [7:0]  v5, t5, p5, m5, v6, t6, p6, m6, v7, t7, p7, m7;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // per-copy code, 2 bits each from copy 0: 0 clean, 1 flip all, 2 stuck 0, 3 stuck 1
  // bit 14: scenario is within the R6/R7 tolerance conditions
  localparam logic [14:0] SCEN [8] = '{
    15'h4000, 15'h6A02, 15'h40C3, 15'h7FC4,
    15'h5510, 15'h000A, 15'h0033, 15'h1540
  };

  split_vote_mult #(.NUM_COPIES(5)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .flip_mask(fl[39:0]), .force_en(fe[39:0]), .force_val(fv[39:0]),
    .vote_out(v5), .trio_out(t5), .pool_out(p5), .mismatch(m5));

  split_vote_mult #(.NUM_COPIES(6)) dut6_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .flip_mask(fl[47:0]), .force_en(fe[47:0]), .force_val(fv[47:0]),
    .vote_out(v6), .trio_out(t6), .pool_out(p6), .mismatch(m6));

  split_vote_mult #(.NUM_COPIES(7)) dut7_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .flip_mask(fl[55:0]), .force_en(fe[55:0]), .force_val(fv[55:0]),
    .vote_out(v7), .trio_out(t7), .pool_out(p7), .mismatch(m7));

  function automatic logic [31:0] model(input logic [3:0] a, input logic [3:0] b,
                                        input logic [55:0] f_l, input logic [55:0] f_e,
                                        input logic [55:0] f_v, input int n);
    logic [7:0] p, m [7], trio, pool;
    p = 8'(a) * 8'(b);
    for (int k = 0; k < 7; k++)
      m[k] = (f_e[k*8 +: 8] & f_v[k*8 +: 8]) | (~f_e[k*8 +: 8] & (p ^ f_l[k*8 +: 8]));
    trio = (m[0] & m[1]) | (m[1] & m[2]) | (m[0] & m[2]);
    pool = '0;
    for (int k = 3; k < n; k++) pool = pool | m[k];
    return {trio & pool, trio, pool, trio ^ pool};
  endfunction

  function automatic logic [31:0] got_of(input int n);
    case (n)
      5: return {v5, t5, p5, m5};
      6: return {v6, t6, p6, m6};
      default: return {v7, t7, p7, m7};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_scen(input logic [14:0] sc);
    fl = '0; fe = '0; fv = '0;
    for (int k = 0; k < 7; k++) begin
      case (sc[2*k +: 2])
        2'd1: fl[k*8 +: 8] = 8'hFF;
        2'd2: fe[k*8 +: 8] = 8'hFF;
        2'd3: begin fe[k*8 +: 8] = 8'hFF; fv[k*8 +: 8] = 8'hFF; end
        default: ;
      endcase
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, all three builds
    for (int n = 5; n <= 7; n++) check("R10 reset state", got_of(n), 32'h0);
    rst = 1'b0;

    // scenario table over every operand pair, R2 R3 R4 R5 R9 via model
    for (int s = 0; s < 8; s++) begin
      load_scen(SCEN[s]);
      for (int ab = 0; ab < 256; ab++) begin
        op_a = ab[7:4];
        op_b = ab[3:0];
        step();
        for (int n = 5; n <= 7; n++) begin
          logic [31:0] e;
          e = model(op_a, op_b, fl, fe, fv, n);
          check($sformatf("R2 R3 R4 R5 R9 scen %0d n %0d a %0d b %0d", s, n, op_a, op_b),
                got_of(n), e);
          if (s == 0)
            check("R1 clean product", got_of(n), {4{8'(op_a) * 8'(op_b)}} & 32'hFFFFFF00
                  | 32'h0);
          if (SCEN[s][14])
            check($sformatf("R6 R7 tolerated scen %0d n %0d", s, n),
                  {24'h0, got_of(n)[31:24]}, {24'h0, 8'(op_a) * 8'(op_b)});
          if (s == 5)
            check("R8 two trio copies pinned low", {24'h0, got_of(n)[31:24]}, 32'h0);
        end
      end
    end

    // R2 field placement: copy 1 bit 2 flipped, 3*5=15, trio still 15
    load_scen(15'h0);
    fl[8 + 2] = 1'b1;
    op_a = 4'd3; op_b = 4'd5;
    step();
    check("R2 R6 single flipped trio bit", {24'h0, v5}, 32'd15);

    // R9: copy 3 bit 0 forced to 1, 2*2=4, pool bit0=1 trio bit0=0
    load_scen(15'h0);
    fe[24] = 1'b1; fv[24] = 1'b1;
    op_a = 4'd2; op_b = 4'd2;
    step();
    check("R9 mismatch flag bit 0", {24'h0, m5}, 32'h01);
    check("R2 R5 vote unaffected by pool fault", {24'h0, v5}, 32'h04);
    check("R4 pool picks forced bit", {24'h0, p5}, 32'h05);

    // R10 latency: outputs hold until the edge
    load_scen(15'h0);
    op_a = 4'd0; op_b = 4'd0;
    step();
    op_a = 4'd15; op_b = 4'd15;
    #1;
    check("R10 output held before edge", {24'h0, v7}, 32'h0);
    step();
    check("R10 output after one edge", {24'h0, v7}, 32'd225);

    // R10 reset with live inputs
    rst = 1'b1;
    step();
    for (int n = 5; n <= 7; n++) check("R10 sync reset clears", got_of(n), 32'h0);
    rst = 1'b0;
    step();
    check("R1 R10 resume after reset", {24'h0, v6}, 32'd225);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule